// File: doc/BRIEF.md
# REX Operand Register Resolver

This block sits in the decode stage of a 64-bit general-purpose-register instruction pipe. It is given the prefix candidate byte, whether an operand-size override (66h) was seen, the primary opcode, a flag saying a ModRM byte follows, and the ModRM and SIB bytes. From these it works out which register operands the instruction names. It produces 4-bit indices for the reg, rm, base and index slots, a valid flag for each slot, a RIP-relative marker and an operand-size code.

A REX prefix does not change every instruction it is attached to. RIP-relative and base-less forms discard B. Opcodes whose ModRM.reg field selects an operation discard R. Forms without a SIB byte discard X. For each of the four REX bits the block reports whether that bit changed the decode, and it raises an inert flag when a REX byte is present but changed nothing. A parameter chooses between same-cycle combinational outputs and a one-cycle registered output stage.

Top module: `rex_operand_resolver`

## Requirements
- R1: A prefix byte counts as REX only when bits 7:4 are 0100b. Bits 3..0 are then W, R, X and B. Any other prefix byte is ignored: decode uses W=R=X=B=0, every effective flag is 0 and rexInert is 0.
- R2: opSize is 2 (64 bits) when W=1, whether or not the 66h flag is set. It is 0 (16 bits) when W=0 and the 66h flag is set, and 1 (32 bits) otherwise.
- R3: With a ModRM byte, regValid=1 and regIdx={R,ModRM[5:3]}. The exception is the group opcodes 80h, 81h, 83h, 8Fh, C0h, C1h, C6h, C7h, D0h–D3h, F6h, F7h, FEh and FFh: for these regValid=0 and R has no effect.
- R4: With ModRM.mod=11b, rmValid=1 and rmIdx={B,ModRM[2:0]}. There is no base and no index, and X has no effect.
- R5: With mod≠11b, rm≠100b, and not the RIP-relative case, baseValid=1 and baseIdx={B,ModRM[2:0]}.
- R6: With mod=00b and rm=101b, ripRel=1. No base or index is produced and B has no effect.
- R7: With mod≠11b and rm=100b a SIB byte is used. The raw index is {X,SIB[5:3]}. A raw value of 4 (X=0 with field 100b) means no index. With X=1 the same field gives index 12.
- R8: In the SIB form, base is {B,SIB[2:0]}. When mod=00b and SIB[2:0]=101b there is no base and B has no effect.
- R9: Opcodes B8h–BFh take regValid=1 and regIdx={B,opcode[2:0]}. The ModRM-present flag is ignored for them, and R and X have no effect.
- R10: effW=W. effR is R when ModRM.reg is a register operand. effX is X when a SIB byte is used. effB is B when an rm, base or opcode-held register is produced. rexInert=1 exactly when a REX byte is present and all four effective flags are 0. Index outputs of invalid slots read 0.
- R11: With REG_OUT=1, outputs show the decode of the inputs present at a rising clock edge from just after that edge, and outValid follows inValid one cycle later. Reset clears the stage. With REG_OUT=0, outputs and outValid follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inValid | input | 1 | Input bytes are meaningful |
| prefixByte | input | 8 | Candidate REX byte |
| opSizePfx | input | 1 | A 66h prefix was seen |
| opcodeByte | input | 8 | Primary opcode |
| hasModrm | input | 1 | A ModRM byte follows the opcode |
| modrmByte | input | 8 | ModRM byte |
| sibByte | input | 8 | SIB byte |
| outValid | output | 1 | Outputs are meaningful |
| regValid | output | 1 | reg slot holds a register |
| regIdx | output | 4 | reg slot index |
| rmValid | output | 1 | rm slot holds a register (mod=11b) |
| rmIdx | output | 4 | rm slot index |
| baseValid | output | 1 | Address has a base register |
| baseIdx | output | 4 | Base register index |
| indexValid | output | 1 | Address has an index register |
| indexIdx | output | 4 | Index register index |
| ripRel | output | 1 | RIP-relative address |
| opSize | output | 2 | 0=16, 1=32, 2=64 bits |
| effW | output | 1 | W changed the decode |
| effR | output | 1 | R changed the decode |
| effX | output | 1 | X changed the decode |
| effB | output | 1 | B changed the decode |
| rexInert | output | 1 | REX present but ignored |

## Verification
The bench builds two copies side by side: one with REG_OUT=1 and one with REG_OUT=0, both driven by the same stimulus. The combinational copy exposes each decode in the cycle it is driven. The registered copy shows the same values one edge later, and its outValid also shows up in the reset check. Driving both copies with the same vectors puts the one-cycle offset of the output stage within reach, next to the full grid of all 16 REX values crossed with every addressing form.

// File: rtl/rexres_pkg.sv
package rexres_pkg;
  localparam int BYTE_W = 8;
  localparam int FLD_W  = 3;
  localparam int IDX_W  = FLD_W + 1;

  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2} opsize_e;

  // strobes from the form classifier to the index datapath
  typedef struct packed {
    logic rexOn;       // prefix byte is a REX byte
    logic opRegForm;   // register sits in opcode[2:0]
    logic regOperand;  // ModRM.reg names a register
    logic rmDirect;    // mod == 11b
    logic baseFromRm;  // memory form, base taken from ModRM.rm
    logic ripRel;      // mod == 00b, rm == 101b
    logic sibOn;       // SIB byte is consumed
    logic sibBase;     // SIB supplies a base register
  } strobes_t;

  typedef struct packed {
    logic             regValid;
    logic [IDX_W-1:0] regIdx;
    logic             rmValid;
    logic [IDX_W-1:0] rmIdx;
    logic             baseValid;
    logic [IDX_W-1:0] baseIdx;
    logic             indexValid;
    logic [IDX_W-1:0] indexIdx;
    logic             ripRel;
    opsize_e          opSize;
    logic             effW;
    logic             effR;
    logic             effX;
    logic             effB;
    logic             rexInert;
  } result_t;

  // opcodes whose ModRM.reg field picks an operation, not a register
  function automatic logic isGroupOp(input logic [BYTE_W-1:0] op);
    case (op)
      8'h80, 8'h81, 8'h83, 8'h8F,
      8'hC0, 8'hC1, 8'hC6, 8'hC7,
      8'hD0, 8'hD1, 8'hD2, 8'hD3,
      8'hF6, 8'hF7, 8'hFE, 8'hFF: isGroupOp = 1'b1;
      default:                    isGroupOp = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rexres_ctrl.sv
module rexres_ctrl
  import rexres_pkg::*;
(
  input  logic [3:0]        prefixHi,
  input  logic [BYTE_W-1:0] opcodeByte,
  input  logic              hasModrm,
  input  logic [BYTE_W-1:0] modrmByte,
  input  logic [FLD_W-1:0]  sibBaseFld,
  output strobes_t          strobes
);
  localparam logic [3:0]   REX_HI    = 4'b0100;
  localparam logic [4:0]   OPREG_HI  = 5'b10111;
  localparam logic [1:0]   MOD_REG   = 2'b11;
  localparam logic [1:0]   MOD_NODSP = 2'b00;
  localparam logic [FLD_W-1:0] FLD_SIB  = 3'b100;
  localparam logic [FLD_W-1:0] FLD_DISP = 3'b101;

  logic [1:0]       modF;
  logic [FLD_W-1:0] rmF;
  logic             useModrm;
  logic             memForm;

  assign modF = modrmByte[7:6];
  assign rmF  = modrmByte[FLD_W-1:0];

  always_comb begin
    strobes           = '0;
    strobes.rexOn     = (prefixHi == REX_HI);
    strobes.opRegForm = (opcodeByte[7:3] == OPREG_HI);
    useModrm          = hasModrm && !strobes.opRegForm;
    memForm           = useModrm && (modF != MOD_REG);
    strobes.regOperand = useModrm && !isGroupOp(opcodeByte);
    strobes.rmDirect   = useModrm && (modF == MOD_REG);
    strobes.ripRel     = memForm && (modF == MOD_NODSP) && (rmF == FLD_DISP);
    strobes.sibOn      = memForm && (rmF == FLD_SIB);
    strobes.baseFromRm = memForm && (rmF != FLD_SIB) && !strobes.ripRel;
    strobes.sibBase    = strobes.sibOn &&
                         !((modF == MOD_NODSP) && (sibBaseFld == FLD_DISP));
  end
endmodule

// File: rtl/rexres_dp.sv
module rexres_dp
  import rexres_pkg::*;
(
  input  strobes_t         strobes,
  input  logic [3:0]       rexBits,
  input  logic             opSizePfx,
  input  logic [FLD_W-1:0] opcodeLo,
  input  logic [FLD_W-1:0] modrmRegF,
  input  logic [FLD_W-1:0] modrmRmF,
  input  logic [FLD_W-1:0] sibIndexF,
  input  logic [FLD_W-1:0] sibBaseF,
  output result_t          res
);
  localparam logic [IDX_W-1:0] NO_INDEX = IDX_W'(4);

  logic bitW, bitR, bitX, bitB;
  logic [IDX_W-1:0] rawIndex;

  assign {bitW, bitR, bitX, bitB} = strobes.rexOn ? rexBits : 4'b0000;
  assign rawIndex = {bitX, sibIndexF};

  always_comb begin
    res = '0;
    // reg slot: opcode-held register wins over ModRM.reg
    res.regValid = strobes.opRegForm || strobes.regOperand;
    if (strobes.opRegForm)       res.regIdx = {bitB, opcodeLo};
    else if (strobes.regOperand) res.regIdx = {bitR, modrmRegF};

    res.rmValid = strobes.rmDirect;
    if (strobes.rmDirect) res.rmIdx = {bitB, modrmRmF};

    res.baseValid = strobes.baseFromRm || strobes.sibBase;
    if (strobes.baseFromRm)   res.baseIdx = {bitB, modrmRmF};
    else if (strobes.sibBase) res.baseIdx = {bitB, sibBaseF};

    res.indexValid = strobes.sibOn && (rawIndex != NO_INDEX);
    if (res.indexValid) res.indexIdx = rawIndex;

    res.ripRel = strobes.ripRel;
    res.opSize = bitW ? SZ64 : (opSizePfx ? SZ16 : SZ32);

    res.effW = bitW;
    res.effR = bitR && strobes.regOperand;
    res.effX = bitX && strobes.sibOn;
    res.effB = bitB && (strobes.opRegForm || strobes.rmDirect || res.baseValid);
    res.rexInert = strobes.rexOn && !(res.effW || res.effR || res.effX || res.effB);
  end
endmodule

// File: rtl/rex_operand_resolver.sv
module rex_operand_resolver
  import rexres_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [7:0]  prefixByte,
  input  logic        opSizePfx,
  input  logic [7:0]  opcodeByte,
  input  logic        hasModrm,
  input  logic [7:0]  modrmByte,
  input  logic [7:0]  sibByte,
  output logic        outValid,
  output logic        regValid,
  output logic [3:0]  regIdx,
  output logic        rmValid,
  output logic [3:0]  rmIdx,
  output logic        baseValid,
  output logic [3:0]  baseIdx,
  output logic        indexValid,
  output logic [3:0]  indexIdx,
  output logic        ripRel,
  output logic [1:0]  opSize,
  output logic        effW,
  output logic        effR,
  output logic        effX,
  output logic        effB,
  output logic        rexInert
);
  strobes_t strobes;
  result_t  resNow;
  result_t  resOut;

  rexres_ctrl u_ctrl (
    .prefixHi   (prefixByte[7:4]),
    .opcodeByte (opcodeByte),
    .hasModrm   (hasModrm),
    .modrmByte  (modrmByte),
    .sibBaseFld (sibByte[2:0]),
    .strobes    (strobes)
  );

  rexres_dp u_dp (
    .strobes   (strobes),
    .rexBits   (prefixByte[3:0]),
    .opSizePfx (opSizePfx),
    .opcodeLo  (opcodeByte[2:0]),
    .modrmRegF (modrmByte[5:3]),
    .modrmRmF  (modrmByte[2:0]),
    .sibIndexF (sibByte[5:3]),
    .sibBaseF  (sibByte[2:0]),
    .res       (resNow)
  );

  generate
    if (REG_OUT) begin : g_reg
      result_t resQ;
      logic    validQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          resQ   <= '0;
          validQ <= 1'b0;
        end else begin
          resQ   <= resNow;
          validQ <= inValid;
        end
      end
      assign resOut   = resQ;
      assign outValid = validQ;

      p_valid_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
    end else begin : g_comb
      assign resOut   = resNow;
      assign outValid = inValid;
    end
  endgenerate

  assign regValid   = resOut.regValid;
  assign regIdx     = resOut.regIdx;
  assign rmValid    = resOut.rmValid;
  assign rmIdx      = resOut.rmIdx;
  assign baseValid  = resOut.baseValid;
  assign baseIdx    = resOut.baseIdx;
  assign indexValid = resOut.indexValid;
  assign indexIdx   = resOut.indexIdx;
  assign ripRel     = resOut.ripRel;
  assign opSize     = resOut.opSize;
  assign effW       = resOut.effW;
  assign effR       = resOut.effR;
  assign effX       = resOut.effX;
  assign effB       = resOut.effB;
  assign rexInert   = resOut.rexInert;

  p_w_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && effW) |-> (opSize == 2'd2));
  p_rip_nobase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && ripRel) |-> (!baseValid && !indexValid && !effB));
  p_regform_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && rmValid) |-> (!baseValid && !indexValid && !ripRel && !effX));
  p_effx_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && effX) |-> (indexValid && indexIdx[3]));
  p_effr_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && effR) |-> (regValid && regIdx[3]));
endmodule

// File: tb/rex_operand_resolver_bench.sv
module rex_operand_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] prefixByte = 8'h00, opcodeByte = 8'h90, modrmByte = 8'h00, sibByte = 8'h00;
  logic opSizePfx = 1'b0, hasModrm = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic rV, rRv, rMv, rBv, rIv, rRip, rW, rR, rX, rB, rIn;
  logic [3:0] rRi, rMi, rBi, rIi;
  logic [1:0] rSz;
  logic cV, cRv, cMv, cBv, cIv, cRip, cW, cR, cX, cB, cIn;
  logic [3:0] cRi, cMi, cBi, cIi;
  logic [1:0] cSz;

  rex_operand_resolver #(.REG_OUT(1'b1)) u_rex_operand_resolver (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .prefixByte(prefixByte),
    .opSizePfx(opSizePfx), .opcodeByte(opcodeByte), .hasModrm(hasModrm),
    .modrmByte(modrmByte), .sibByte(sibByte), .outValid(rV),
    .regValid(rRv), .regIdx(rRi), .rmValid(rMv), .rmIdx(rMi),
    .baseValid(rBv), .baseIdx(rBi), .indexValid(rIv), .indexIdx(rIi),
    .ripRel(rRip), .opSize(rSz), .effW(rW), .effR(rR), .effX(rX),
    .effB(rB), .rexInert(rIn));

  rex_operand_resolver #(.REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .prefixByte(prefixByte),
    .opSizePfx(opSizePfx), .opcodeByte(opcodeByte), .hasModrm(hasModrm),
    .modrmByte(modrmByte), .sibByte(sibByte), .outValid(cV),
    .regValid(cRv), .regIdx(cRi), .rmValid(cMv), .rmIdx(cMi),
    .baseValid(cBv), .baseIdx(cBi), .indexValid(cIv), .indexIdx(cIi),
    .ripRel(cRip), .opSize(cSz), .effW(cW), .effR(cR), .effX(cX),
    .effB(cB), .rexInert(cIn));

  wire [28:0] regVec  = {rV, rRv, rRi, rMv, rMi, rBv, rBi, rIv, rIi, rRip, rSz, rW, rR, rX, rB, rIn};
  wire [28:0] combVec = {cV, cRv, cRi, cMv, cMi, cBv, cBi, cIv, cIi, cRip, cSz, cW, cR, cX, cB, cIn};

  // expected packed outputs, built from the requirement text
  function automatic logic [28:0] model(input logic [7:0] p, input logic o66,
      input logic [7:0] op, input logic hm, input logic [7:0] m, input logic [7:0] s);
    logic isRex, w, r, x, b, grp;
    logic gv, mv, bv, iv, rip, ew, er, ex, eb;
    logic [3:0] gi, mi, bi, ii;
    logic [1:0] sz;
    isRex = (p >= 8'h40) && (p <= 8'h4F);
    w = isRex & p[3]; r = isRex & p[2]; x = isRex & p[1]; b = isRex & p[0];
    grp = op inside {8'h80, 8'h81, 8'h83, 8'h8F, 8'hC0, 8'hC1, 8'hC6, 8'hC7,
                     8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hF6, 8'hF7, 8'hFE, 8'hFF};
    gv = 0; mv = 0; bv = 0; iv = 0; rip = 0; gi = 0; mi = 0; bi = 0; ii = 0;
    er = 0; ex = 0; eb = 0;
    if (op >= 8'hB8 && op <= 8'hBF) begin              // R9
      gv = 1; gi = {b, op[2:0]}; eb = b;
    end else if (hm) begin
      if (!grp) begin gv = 1; gi = {r, m[5:3]}; er = r; end   // R3
      if (m[7:6] == 2'b11) begin                        // R4
        mv = 1; mi = {b, m[2:0]}; eb = b;
      end else if (m[2:0] == 3'b100) begin              // R7, R8
        ex = x;
        if ({x, s[5:3]} != 4'd4) begin iv = 1; ii = {x, s[5:3]}; end
        if (!(m[7:6] == 2'b00 && s[2:0] == 3'b101)) begin bv = 1; bi = {b, s[2:0]}; eb = b; end
      end else if (m[7:6] == 2'b00 && m[2:0] == 3'b101) begin
        rip = 1;                                        // R6
      end else begin
        bv = 1; bi = {b, m[2:0]}; eb = b;               // R5
      end
    end
    ew = w;
    sz = w ? 2'd2 : (o66 ? 2'd0 : 2'd1);
    model = {1'b1, gv, gi, mv, mi, bv, bi, iv, ii, rip, sz, ew, er, ex, eb,
             isRex && !(ew | er | ex | eb)};
  endfunction

  function automatic string formTag(input logic [7:0] op, input logic hm,
      input logic [7:0] m, input logic [7:0] s);
    if (op >= 8'hB8 && op <= 8'hBF) return "R9";
    if (!hm) return "R1";
    if (m[7:6] == 2'b11) return "R4";
    if (m[2:0] == 3'b100) return (m[7:6] == 2'b00 && s[2:0] == 3'b101) ? "R8" : "R7";
    if (m[7:6] == 2'b00 && m[2:0] == 3'b101) return "R6";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] p, input logic o66, input logic [7:0] op,
      input logic hm, input logic [7:0] m, input logic [7:0] s);
    logic [28:0] exp;
    string tag;
    exp = model(p, o66, op, hm, m, s);
    tag = formTag(op, hm, m, s);
    @(negedge clk);
    prefixByte = p; opSizePfx = o66; opcodeByte = op; hasModrm = hm;
    modrmByte = m; sibByte = s; inValid = 1'b1;
    #1 chk({tag, " comb"}, 32'(combVec), 32'(exp));
    @(posedge clk);
    #1 chk({tag, " R11 registered"}, 32'(regVec), 32'(exp));
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] opsA [11];
    logic [7:0] mA [11];
    logic [7:0] sA [11];
    logic       hA [11];
    void'($urandom(32'h1D2C3B4A));
    opsA = '{8'hAD, 8'hC7, 8'hB8, 8'hC1, 8'hC7, 8'h11, 8'h1B, 8'h29, 8'h39, 8'h21, 8'h33};
    mA   = '{8'h00, 8'h05, 8'h00, 8'hC8, 8'h04, 8'h01, 8'hCA, 8'h04, 8'h04, 8'h05, 8'h04};
    sA   = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h5D, 8'h00, 8'h00, 8'h91, 8'hE1, 8'h00, 8'h5D};
    hA   = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    repeat (3) @(posedge clk);
    #1 chk("R11 reset outValid", 32'(rV), 32'd0);
    chk("R11 reset outputs", 32'(regVec), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // every REX value against every addressing form
    for (int f = 0; f < 11; f++)
      for (int r = 0; r < 16; r++)
        apply(8'h40 + 8'(r), 1'b0, opsA[f], hA[f], mA[f], sA[f]);

    // directed corners with literal expectations
    apply(8'h41, 1'b0, 8'hB8, 1'b0, 8'h00, 8'h00);
    chk("R9 opreg idx", {rRv, rRi, rB}, {1'b1, 4'd8, 1'b1});
    apply(8'h46, 1'b0, 8'hB8, 1'b1, 8'hC0, 8'h00);
    chk("R9 R/X inert", {rR, rX, rIn}, 3'b001);
    apply(8'h44, 1'b0, 8'hC1, 1'b1, 8'hC8, 8'h00);
    chk("R3 group reg inert", {rRv, rR, rIn}, 3'b001);
    apply(8'h42, 1'b0, 8'h39, 1'b1, 8'h04, 8'hE1);
    chk("R7 index 12", {rIv, rIi, rX}, {1'b1, 4'd12, 1'b1});
    apply(8'h40, 1'b0, 8'h39, 1'b1, 8'h04, 8'hE1);
    chk("R7 no index", {rIv, rIi}, 5'd0);
    apply(8'h41, 1'b0, 8'h33, 1'b1, 8'h04, 8'h5D);
    chk("R8 base-less B inert", {rBv, rB, rIn}, 3'b001);
    apply(8'h41, 1'b0, 8'h21, 1'b1, 8'h05, 8'h00);
    chk("R6 rip B inert", {rRip, rBv, rB, rIn}, 4'b1001);
    apply(8'h48, 1'b1, 8'h83, 1'b1, 8'hC8, 8'h00);
    chk("R2 66h ignored under W", 32'(rSz), 32'd2);
    apply(8'h90, 1'b1, 8'h1B, 1'b1, 8'hCA, 8'h00);
    chk("R2 16-bit", 32'(rSz), 32'd0);
    apply(8'h55, 1'b0, 8'h1B, 1'b1, 8'hCA, 8'h00);
    chk("R1 non-REX byte ignored", {rRi, rMi, rW, rR, rX, rB, rIn}, {4'd1, 4'd2, 5'b00000});
    apply(8'h47, 1'b0, 8'h1B, 1'b1, 8'hCA, 8'h00);
    chk("R10 reg/reg flags", {rRi, rMi, rR, rX, rB, rIn}, {4'd9, 4'd10, 4'b1010});
    apply(8'h45, 1'b0, 8'h29, 1'b1, 8'h44, 8'h91);
    chk("R5 R10 sib+disp8", {rBi, rIi, rR, rB}, {4'd9, 4'd2, 2'b11});
    apply(8'h4D, 1'b0, 8'h8B, 1'b1, 8'h83, 8'h00);
    chk("R5 base from rm", {rBv, rBi, rRi}, {1'b1, 4'd11, 4'd8});

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] p, op, m, s;
      logic o66, hm;
      p   = ($urandom % 4 == 0) ? 8'($urandom) : (8'h40 | 8'($urandom % 16));
      o66 = 1'($urandom);
      case ($urandom % 4)
        0: op = 8'hB8 | 8'($urandom % 8);
        1: op = (($urandom % 2) == 0) ? 8'hC7 : 8'hFF;
        default: op = 8'($urandom);
      endcase
      hm = ($urandom % 8) != 0;
      m  = 8'($urandom);
      s  = 8'($urandom);
      apply(p, o66, op, hm, m, s);
    end

    @(negedge clk); inValid = 1'b0;
    #1 chk("R11 comb outValid drop", 32'(cV), 32'd0);
    @(posedge clk);
    #1 chk("R11 registered outValid drop", 32'(rV), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule